// File: doc/BRIEF.md
# Peripheral Power Reduction Gate

This block sits between a simple register bus and a group of peripheral modules. For each module it keeps one "off" bit. An off bit stops the module's clock enable and closes the module's register window. No write reaches a disabled module and no read returns its data. Because the module sees neither clock nor access, its state stays frozen rather than reset. When the bit is cleared, the module continues from exactly the state it was in.

The address space is split into windows of `2**WIN_BITS` bytes, selected by the upper address bits. Window 0 holds the gate's own control words. Window `k+1` belongs to module `k`. The control words are reachable in three ways:
- a direct copy, where a write replaces the word;
- a set alias, where each 1 written sets that bit;
- a clear alias, where each 1 written clears that bit.

Read data is registered. It appears one cycle after the read strobe and is held until the next read.

Top module: `periph_pwr_gate`

## Requirements
- R1: After reset every off bit is 0. Every `modClkEn` bit is 1, `busRdata` is 0, and the control word reads back as 0.
- R2: A write to window 0 at offset `w` (for `w` below NW, with NW = ceil(NUM_MODS/DATA_W)) replaces control word `w`. Bit `j` of word `w` is the off bit of module `w*DATA_W+j`, and 1 means off. A read at offset `w`, `NW+w` or `2*NW+w` returns that word, with bits beyond NUM_MODS reading 0.
- R3: A write at offset `NW+w` sets each off bit whose data bit is 1. A write at offset `2*NW+w` clears each off bit whose data bit is 1. Data bits that are 0 leave their off bits unchanged.
- R4: `modClkEn[i]` is 0 while off bit `i` is 1. It is also 0 during the very cycle in which a write sets off bit `i`, so the module does not advance at the edge that stores the disable.
- R5: When a write clears off bit `i`, `modClkEn[i]` stays 0 during that write cycle and is 1 from the following cycle.
- R6: A write to window `k+1` raises `modWrEn[k]` in that cycle only while module `k` is enabled. Otherwise the write is dropped.
- R7: A read of the window of a disabled module keeps `modRdEn` low and returns 0 on `busRdata`, with no error indication.
- R8: A read of the window of an enabled module raises `modRdEn[k]`. `busRdata` then takes the value present on that module's slice of `modRdata` at the read edge, and holds it until the next read.
- R9: A module disabled and later re-enabled shows the same state it had when it was disabled.
- R10: The control words stay readable and writable whatever the off bits hold, including all modules off.
- R11: Reads of windows above NUM_MODS, or of window-0 offsets at or above `3*NW`, return 0. Writes to those addresses change no off bit and raise no `modWrEn`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busAddr | input | ADDR_W | Byte address: upper bits select the window, lower WIN_BITS the offset |
| busWdata | input | DATA_W | Write data |
| busWr | input | 1 | Write strobe, one cycle per write |
| busRd | input | 1 | Read strobe, one cycle per read |
| busRdata | output | DATA_W | Registered read data, held between reads |
| modClkEn | output | NUM_MODS | Clock enable per module |
| modWrEn | output | NUM_MODS | Qualified write strobe per module |
| modRdEn | output | NUM_MODS | Qualified read strobe per module |
| modOffset | output | WIN_BITS | Register offset within the module window |
| modWdata | output | DATA_W | Write data passed to the modules |
| modRdata | input | NUM_MODS*DATA_W | Read data of all modules; module k in bits k*DATA_W upward |

## Verification
The assertions take for granted that `busWr` and `busRd` are never high in the same cycle. Under that rule, a control-word write and a module access cannot coincide, and the read path always captures a single source. They also assume that each strobe marks exactly one transfer. The stimulus keeps within this by issuing one transfer per task, driving every input on the falling edge, and dropping each strobe after a single cycle.

// File: rtl/ppg_pkg.sv
package ppg_pkg;

  // Strobes produced by the address decode, consumed by the datapath
  typedef struct packed {
    logic wrDirect;  // replace a control word
    logic wrSet;     // set control bits written as 1
    logic wrClr;     // clear control bits written as 1
    logic rdCtrl;    // read a control word (any alias)
    logic wrMod;     // write into some module window
    logic rdMod;     // read from some module window
  } gateStrobes_t;

  function automatic int ceilDiv(input int a, input int b);
    return (a + b - 1) / b;
  endfunction

endpackage

// File: rtl/ppg_decode.sv
module ppg_decode
  import ppg_pkg::*;
#(
  parameter int NUM_MODS = 8,
  parameter int DATA_W   = 8,
  parameter int ADDR_W   = 8,
  parameter int WIN_BITS = 4,
  localparam int WIN_IDX_W = ADDR_W - WIN_BITS,
  localparam int NW        = ceilDiv(NUM_MODS, DATA_W),
  localparam int WORD_W    = (NW > 1) ? $clog2(NW) : 1
) (
  input  logic [ADDR_W-1:0]    busAddr,
  input  logic                 busWr,
  input  logic                 busRd,
  output gateStrobes_t         strb,
  output logic [WORD_W-1:0]    ctrlWord,
  output logic [WIN_IDX_W-1:0] modIdx
);

  localparam logic [WIN_BITS:0]    SET_BASE = (WIN_BITS+1)'(NW);
  localparam logic [WIN_BITS:0]    CLR_BASE = (WIN_BITS+1)'(2 * NW);
  localparam logic [WIN_BITS:0]    END_OFF  = (WIN_BITS+1)'(3 * NW);
  localparam logic [WIN_IDX_W-1:0] MAX_WIN  = WIN_IDX_W'(NUM_MODS);

  logic [WIN_IDX_W-1:0] winIdx;
  logic [WIN_BITS:0]    offsetX;
  logic ctrlHit, modHit;
  logic inDirect, inSet, inClr;

  always_comb begin
    winIdx   = busAddr[ADDR_W-1:WIN_BITS];
    offsetX  = {1'b0, busAddr[WIN_BITS-1:0]};
    ctrlHit  = (winIdx == '0);
    modHit   = (winIdx != '0) && (winIdx <= MAX_WIN);
    inDirect = (offsetX < SET_BASE);
    inSet    = (offsetX >= SET_BASE) && (offsetX < CLR_BASE);
    inClr    = (offsetX >= CLR_BASE) && (offsetX < END_OFF);

    if (inDirect)   ctrlWord = WORD_W'(offsetX);
    else if (inSet) ctrlWord = WORD_W'(offsetX - SET_BASE);
    else            ctrlWord = WORD_W'(offsetX - CLR_BASE);

    modIdx = winIdx - WIN_IDX_W'(1);

    strb.wrDirect = busWr && ctrlHit && inDirect;
    strb.wrSet    = busWr && ctrlHit && inSet;
    strb.wrClr    = busWr && ctrlHit && inClr;
    strb.rdCtrl   = busRd && ctrlHit && (offsetX < END_OFF);
    strb.wrMod    = busWr && modHit;
    strb.rdMod    = busRd && modHit;
  end

  // Decode is one-hot: at most one control-write flavour per cycle
  always_comb begin
    AST_ONE_CTRL_OP: assert ($onehot0({strb.wrDirect, strb.wrSet, strb.wrClr}) || $isunknown(busAddr)); // R3
  end

endmodule

// File: rtl/ppg_lane.sv
module ppg_lane (
  input  logic clk,
  input  logic rstN,
  input  logic offBit,   // stored off bit
  input  logic nextBit,  // value the bit takes at the coming edge
  input  logic laneSel,  // this module's window is addressed
  input  logic wrMod,
  input  logic rdMod,
  output logic clkEn,
  output logic wrEn,
  output logic rdEn
);

  // Low when off now, and already low in the cycle a disable is written.
  // A cleared bit only re-enables once the stored bit has fallen.
  assign clkEn = ~(offBit | nextBit);
  assign wrEn  = laneSel & wrMod & ~offBit;
  assign rdEn  = laneSel & rdMod & ~offBit;

  AST_DISABLE_EDGE_FROZEN: assert property (@(posedge clk) disable iff (!rstN)
    $rose(offBit) |-> $past(!clkEn)); // R4

  AST_ENABLE_EDGE_FROZEN: assert property (@(posedge clk) disable iff (!rstN)
    $fell(offBit) |-> $past(!clkEn)); // R5

  AST_NO_ACCESS_WHEN_GATED: assert property (@(posedge clk) disable iff (!rstN)
    !clkEn |-> (!wrEn && !rdEn)); // R6

endmodule

// File: rtl/ppg_datapath.sv
module ppg_datapath
  import ppg_pkg::*;
#(
  parameter int NUM_MODS = 8,
  parameter int DATA_W   = 8,
  parameter int ADDR_W   = 8,
  parameter int WIN_BITS = 4,
  localparam int WIN_IDX_W = ADDR_W - WIN_BITS,
  localparam int NW        = ceilDiv(NUM_MODS, DATA_W),
  localparam int WORD_W    = (NW > 1) ? $clog2(NW) : 1,
  localparam int CTRL_W    = NW * DATA_W
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  gateStrobes_t               strb,
  input  logic [WORD_W-1:0]          ctrlWord,
  input  logic [WIN_IDX_W-1:0]       modIdx,
  input  logic [DATA_W-1:0]          busWdata,
  input  logic                       busRd,
  input  logic [NUM_MODS*DATA_W-1:0] modRdata,
  output logic [DATA_W-1:0]          busRdata,
  output logic [NUM_MODS-1:0]        modClkEn,
  output logic [NUM_MODS-1:0]        modWrEn,
  output logic [NUM_MODS-1:0]        modRdEn
);

  logic [NUM_MODS-1:0] offBits;
  logic [NUM_MODS-1:0] nextBits;

  // Per-bit next value of the control register, all three write flavours
  for (genvar i = 0; i < NUM_MODS; i++) begin : g_bit
    localparam int WRD = i / DATA_W;
    localparam int POS = i % DATA_W;
    logic wordHit;
    always_comb begin
      wordHit = (ctrlWord == WORD_W'(WRD));
      if (strb.wrDirect && wordHit)   nextBits[i] = busWdata[POS];
      else if (strb.wrSet && wordHit) nextBits[i] = offBits[i] | busWdata[POS];
      else if (strb.wrClr && wordHit) nextBits[i] = offBits[i] & ~busWdata[POS];
      else                            nextBits[i] = offBits[i];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) offBits <= '0;
    else       offBits <= nextBits;
  end

  // One gating lane per module
  for (genvar i = 0; i < NUM_MODS; i++) begin : g_lane
    logic laneSel;
    assign laneSel = (modIdx == WIN_IDX_W'(i));
    ppg_lane u_lane (
      .clk    (clk),
      .rstN   (rstN),
      .offBit (offBits[i]),
      .nextBit(nextBits[i]),
      .laneSel(laneSel),
      .wrMod  (strb.wrMod),
      .rdMod  (strb.rdMod),
      .clkEn  (modClkEn[i]),
      .wrEn   (modWrEn[i]),
      .rdEn   (modRdEn[i])
    );
  end

  // Read path
  logic [CTRL_W-1:0] offPad;
  logic [DATA_W-1:0] ctrlData;
  logic [DATA_W-1:0] modData;
  logic              selOff;
  logic [DATA_W-1:0] rdNext;

  always_comb begin
    offPad = '0;
    offPad[NUM_MODS-1:0] = offBits;
    ctrlData = '0;
    for (int w = 0; w < NW; w++) begin
      if (ctrlWord == WORD_W'(w)) ctrlData = offPad[w*DATA_W +: DATA_W];
    end
    modData = '0;
    selOff  = 1'b0;
    for (int k = 0; k < NUM_MODS; k++) begin
      if (modIdx == WIN_IDX_W'(k)) begin
        modData = modRdata[k*DATA_W +: DATA_W];
        selOff  = offBits[k];
      end
    end
    if (strb.rdCtrl)               rdNext = ctrlData;
    else if (strb.rdMod && !selOff) rdNext = modData;
    else                           rdNext = '0;
  end

  // Register loads only on a read strobe and holds otherwise
  always_ff @(posedge clk) begin
    if (!rstN)      busRdata <= '0;
    else if (busRd) busRdata <= rdNext;
  end

  AST_OFF_READ_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (strb.rdMod && selOff) |=> (busRdata == '0)); // R7

  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !busRd |=> $stable(busRdata)); // R8

  AST_BITS_NEED_CTRL_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    !(strb.wrDirect || strb.wrSet || strb.wrClr) |=> $stable(offBits)); // R11

  AST_CTRL_READ_MATCH: assert property (@(posedge clk) disable iff (!rstN)
    (strb.rdCtrl && ctrlWord == '0) |=> (busRdata[0] == offBits[0])); // R2

endmodule

// File: rtl/periph_pwr_gate.sv
module periph_pwr_gate
  import ppg_pkg::*;
#(
  parameter int NUM_MODS = 8,
  parameter int DATA_W   = 8,
  parameter int ADDR_W   = 8,
  parameter int WIN_BITS = 4
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic [ADDR_W-1:0]          busAddr,
  input  logic [DATA_W-1:0]          busWdata,
  input  logic                       busWr,
  input  logic                       busRd,
  output logic [DATA_W-1:0]          busRdata,
  output logic [NUM_MODS-1:0]        modClkEn,
  output logic [NUM_MODS-1:0]        modWrEn,
  output logic [NUM_MODS-1:0]        modRdEn,
  output logic [WIN_BITS-1:0]        modOffset,
  output logic [DATA_W-1:0]          modWdata,
  input  logic [NUM_MODS*DATA_W-1:0] modRdata
);

  localparam int WIN_IDX_W = ADDR_W - WIN_BITS;
  localparam int NW        = ceilDiv(NUM_MODS, DATA_W);
  localparam int WORD_W    = (NW > 1) ? $clog2(NW) : 1;

  gateStrobes_t         strb;
  logic [WORD_W-1:0]    ctrlWord;
  logic [WIN_IDX_W-1:0] modIdx;

  assign modOffset = busAddr[WIN_BITS-1:0];
  assign modWdata  = busWdata;

  ppg_decode #(
    .NUM_MODS(NUM_MODS), .DATA_W(DATA_W), .ADDR_W(ADDR_W), .WIN_BITS(WIN_BITS)
  ) u_decode (
    .busAddr (busAddr),
    .busWr   (busWr),
    .busRd   (busRd),
    .strb    (strb),
    .ctrlWord(ctrlWord),
    .modIdx  (modIdx)
  );

  ppg_datapath #(
    .NUM_MODS(NUM_MODS), .DATA_W(DATA_W), .ADDR_W(ADDR_W), .WIN_BITS(WIN_BITS)
  ) u_datapath (
    .clk     (clk),
    .rstN    (rstN),
    .strb    (strb),
    .ctrlWord(ctrlWord),
    .modIdx  (modIdx),
    .busWdata(busWdata),
    .busRd   (busRd),
    .modRdata(modRdata),
    .busRdata(busRdata),
    .modClkEn(modClkEn),
    .modWrEn (modWrEn),
    .modRdEn (modRdEn)
  );

  // Input rule the read path relies on: one transfer per cycle
  AST_BUS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rstN)
    !(busWr && busRd)); // R8

endmodule

// File: tb/tb_periph_pwr_gate.sv
`timescale 1ns/1ps
module tb_periph_pwr_gate;

  localparam int N  = 8;
  localparam int DW = 8;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic [7:0]    busAddr = '0;
  logic [DW-1:0] busWdata = '0;
  logic          busWr = 1'b0;
  logic          busRd = 1'b0;
  logic [DW-1:0] busRdata;
  logic [N-1:0]  modClkEn, modWrEn, modRdEn;
  logic [3:0]    modOffset;
  logic [DW-1:0] modWdata;
  logic [N*DW-1:0] modRdata;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;
  logic [N-1:0] snapClk, snapWr, snapRd;

  always #4 clk = ~clk;  // 125 MHz

  periph_pwr_gate dut (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWdata(busWdata),
    .busWr(busWr), .busRd(busRd), .busRdata(busRdata),
    .modClkEn(modClkEn), .modWrEn(modWrEn), .modRdEn(modRdEn),
    .modOffset(modOffset), .modWdata(modWdata), .modRdata(modRdata)
  );

  // Stand-in peripherals: free-running counters, loadable through the bus
  logic [DW-1:0] cnt [N];
  for (genvar i = 0; i < N; i++) begin : g_periph
    always_ff @(posedge clk) begin
      if (!rstN)            cnt[i] <= '0;
      else if (modWrEn[i])  cnt[i] <= modWdata;
      else if (modClkEn[i]) cnt[i] <= cnt[i] + 8'd1;
    end
  end
  always_comb begin
    for (int i = 0; i < N; i++) modRdata[i*DW +: DW] = cnt[i];
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic busWrite(input logic [7:0] a, input logic [DW-1:0] d);
    busAddr = a; busWdata = d; busWr = 1'b1;
    #1; snapClk = modClkEn; snapWr = modWrEn; snapRd = modRdEn;
    @(negedge clk); busWr = 1'b0;
  endtask

  task automatic busRead(input logic [7:0] a, output logic [DW-1:0] d);
    busAddr = a; busRd = 1'b1;
    #1; snapClk = modClkEn; snapWr = modWrEn; snapRd = modRdEn;
    @(negedge clk); busRd = 1'b0; d = busRdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [DW-1:0] d;
    check("R1 clock enables after reset", modClkEn, 8'hFF);
    check("R1 read data after reset", busRdata, 8'h00);
    busRead(8'h00, d);
    check("R1 control word after reset", d, 8'h00);
  endtask

  task automatic t_direct();
    logic [DW-1:0] d;
    busWrite(8'h00, 8'hA5);
    check("R2 enables follow direct write", modClkEn, 8'h5A);
    busRead(8'h00, d); check("R2 readback direct offset", d, 8'hA5);
    busRead(8'h01, d); check("R2 readback set alias", d, 8'hA5);
    busRead(8'h02, d); check("R2 readback clear alias", d, 8'hA5);
    busWrite(8'h00, 8'h00);
  endtask

  task automatic t_alias();
    logic [DW-1:0] d;
    busWrite(8'h00, 8'h0F);
    busWrite(8'h01, 8'h30);
    busRead(8'h00, d); check("R3 set alias", d, 8'h3F);
    busWrite(8'h02, 8'h05);
    busRead(8'h00, d); check("R3 clear alias", d, 8'h3A);
    check("R3 enables after aliases", modClkEn, 8'hC5);
    busWrite(8'h00, 8'h00);
  endtask

  task automatic t_freeze();
    logic [DW-1:0] d;
    busWrite(8'h30, 8'h11);                 // module 2 counter := 0x11
    busWrite(8'h01, 8'h04);                 // set off bit 2
    check("R4 enable low in disabling cycle", snapClk[2], 1'b0);
    check("R4 enable low while off", modClkEn[2], 1'b0);
    busWrite(8'h30, 8'h55);
    check("R6 write to disabled module dropped", snapWr, 8'h00);
    busRead(8'h31, d);
    check("R7 read strobe blocked", snapRd, 8'h00);
    check("R7 disabled read returns zero", d, 8'h00);
    idle(10);
    busWrite(8'h02, 8'h04);                 // clear off bit 2
    check("R5 enable still low in enabling cycle", snapClk[2], 1'b0);
    check("R5 enable high next cycle", modClkEn[2], 1'b1);
    busRead(8'h30, d);
    check("R9 state resumed unchanged", d, 8'h11);
  endtask

  task automatic t_enabled_read();
    logic [DW-1:0] d;
    busWrite(8'h60, 8'h40);                 // module 5
    check("R6 write reaches enabled module", snapWr, 8'h20);
    busRead(8'h60, d);
    check("R8 read strobe to enabled module", snapRd, 8'h20);
    check("R8 read data of enabled module", d, 8'h40);
    idle(3);
    check("R8 read data held", busRdata, 8'h40);
  endtask

  task automatic t_all_off();
    logic [DW-1:0] d;
    busWrite(8'h00, 8'hFF);
    check("R10 all enables low", modClkEn, 8'h00);
    busRead(8'h00, d); check("R10 control readable all off", d, 8'hFF);
    busWrite(8'h02, 8'hFF);
    busRead(8'h01, d); check("R10 control writable all off", d, 8'h00);
  endtask

  task automatic t_unmapped();
    logic [DW-1:0] d;
    busWrite(8'h00, 8'h3C);
    busRead(8'h00, d);
    busRead(8'h90, d); check("R11 unmapped window reads zero", d, 8'h00);
    busWrite(8'h93, 8'hFF);
    check("R11 unmapped write raises no strobe", snapWr, 8'h00);
    busWrite(8'h03, 8'hFF);
    busRead(8'h03, d); check("R11 unused control offset reads zero", d, 8'h00);
    busRead(8'h00, d); check("R11 control unchanged", d, 8'h3C);
    busWrite(8'h00, 8'h00);
  endtask

  initial begin
    idle(3);
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_direct();
    t_alias();
    t_freeze();
    t_enabled_read();
    t_all_off();
    t_unmapped();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual running expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule